// File: doc/BRIEF.md
# Logic Analyzer Host Command Decoder

This block sits behind a byte-wide host link on a logic analyzer and turns the incoming byte stream into capture settings and control events. A command is either a single opcode byte or an opcode byte followed by four argument bytes. The long commands load a 24-bit sample-rate divider, a 32-bit read count, a 32-bit delay count and a 16-bit flag word. The short commands pulse an arm strobe or a reset strobe, or ask for a four-byte identification reply, which leaves through a valid/ready transmit port.

Bytes arrive on a valid/ready receive port. The parser tracks how many argument bytes of a long command it has taken. A host that has lost count sends five 0x00 bytes: any long command in progress is completed by some of those zeros, and the last zero is always taken as a reset opcode. After that the parser is known to be waiting for an opcode. While the identification reply is being sent the receive port is not ready, so replies never overlap.

Top module: `la_cmd_decoder`

## Requirements
- R1: After reset, divider, readCount, delayCount and flags are zero, armPulse, resetPulse and txValid are low and rxReady is high.
- R2: Opcode 0x01 accepted as an opcode makes armPulse high for exactly the one cycle after the accepting clock edge.
- R3: Opcode 0x00 accepted as an opcode makes resetPulse high for exactly the one cycle after the accepting edge. It leaves every register unchanged.
- R4: Opcode 0x02 starts a reply of four bytes, in the order 0x31, 0x53, 0x4C, 0x4F, with txValid high from the cycle after the accepting edge. txData holds while txValid is high and txReady is low.
- R5: rxReady is low from the cycle after the identify opcode is accepted until the last reply byte has been taken, and high again in the next cycle.
- R6: An opcode with bit 7 set is followed by four argument bytes, least significant first. The target register takes its new value at the edge that accepts the fourth argument byte. Registers change at no other time.
- R7: Opcode 0x80 loads divider from argument bits 23:0. Argument bits 31:24 are dropped.
- R8: Opcode 0x81 loads readCount and opcode 0x83 loads delayCount, each with all 32 argument bits.
- R9: Opcode 0x82 loads flags from argument bits 15:0.
- R10: A short opcode other than 0x00, 0x01 and 0x02 changes no output, and the next byte is taken as an opcode. A long opcode other than 0x80 to 0x83 consumes four argument bytes and changes no register.
- R11: Five consecutive 0x00 bytes, sent after any number of argument bytes of a long command, end with a resetPulse on the fifth. The byte that follows is taken as an opcode. Zeros that complete a pending long command act as its arguments.
- R12: Argument bytes equal to 0x00, 0x01 or 0x02 raise no strobe and start no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxValid | input | 1 | Host byte is present |
| rxData | input | 8 | Host byte |
| rxReady | output | 1 | Decoder accepts a host byte this cycle |
| txValid | output | 1 | Reply byte is present |
| txData | output | 8 | Reply byte |
| txReady | input | 1 | Link takes the reply byte this cycle |
| armPulse | output | 1 | One-cycle arm strobe |
| resetPulse | output | 1 | One-cycle reset strobe |
| divider | output | 24 | Sample-rate divider |
| readCount | output | 32 | Read count minus one |
| delayCount | output | 32 | Delay count minus one |
| flags | output | 16 | Capture flag word |

## Verification
Registers are written at the same edge that accepts the fourth argument byte. Strobes and the first reply byte appear in the cycle after the accepting edge. The bench drives each byte at a falling edge, waits for rxReady, lets one rising edge accept it and samples at the next falling edge. That falling edge is inside the cycle where both the strobes and the new register values are due. Reply bytes are sampled at each falling edge before the rising edge that takes them, and stalls are checked by holding txReady low over several such samples.

// File: rtl/la_cmd_pkg.sv
package la_cmd_pkg;

  localparam int BYTE_W   = 8;
  localparam int ID_LEN   = 4;
  localparam int ID_IDX_W = $clog2(ID_LEN);

  localparam logic [BYTE_W-1:0] OP_RESET = 8'h00;
  localparam logic [BYTE_W-1:0] OP_ARM   = 8'h01;
  localparam logic [BYTE_W-1:0] OP_IDENT = 8'h02;
  localparam logic [BYTE_W-1:0] OP_DIV   = 8'h80;
  localparam logic [BYTE_W-1:0] OP_READ  = 8'h81;
  localparam logic [BYTE_W-1:0] OP_FLAGS = 8'h82;
  localparam logic [BYTE_W-1:0] OP_DELAY = 8'h83;

  // control-to-datapath strobes for one accepted byte
  typedef struct packed {
    logic latchOp;   // byte is a long opcode
    logic shiftArg;  // byte is an argument byte
    logic commit;    // byte is the last argument byte
  } ctrl_strobe_t;

  function automatic logic [BYTE_W-1:0] idByte(input logic [ID_IDX_W-1:0] idx);
    case (idx)
      2'd0:    return 8'h31;
      2'd1:    return 8'h53;
      2'd2:    return 8'h4C;
      default: return 8'h4F;
    endcase
  endfunction

endpackage

// File: rtl/la_cmd_ctrl.sv
module la_cmd_ctrl
  import la_cmd_pkg::*;
#(
  parameter int ARG_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rxValid,
  input  logic [BYTE_W-1:0]   rxData,
  output logic                rxReady,
  output logic                txValid,
  input  logic                txReady,
  output logic [ID_IDX_W-1:0] replyIdx,
  output ctrl_strobe_t        stb,
  output logic                armPulse,
  output logic                resetPulse
);

  localparam int IDX_W = (ARG_BYTES > 1) ? $clog2(ARG_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_ARG = IDX_W'(ARG_BYTES - 1);

  logic             inLong;
  logic [IDX_W-1:0] argIdx;
  logic             replyActive;
  logic             accept;
  logic             takeOp;
  logic             txFire;

  assign rxReady = !replyActive;
  assign txValid = replyActive;
  assign accept  = rxValid && rxReady;
  assign takeOp  = accept && !inLong;
  assign txFire  = replyActive && txReady;

  always_comb begin
    stb.latchOp  = takeOp && rxData[BYTE_W-1];
    stb.shiftArg = accept && inLong;
    stb.commit   = accept && inLong && (argIdx == LAST_ARG);
  end

  // argument position tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      inLong <= 1'b0;
      argIdx <= '0;
    end else if (stb.latchOp) begin
      inLong <= 1'b1;
      argIdx <= '0;
    end else if (stb.shiftArg) begin
      if (argIdx == LAST_ARG) inLong <= 1'b0;
      argIdx <= argIdx + 1'b1;
    end
  end

  // short command strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      armPulse   <= 1'b0;
      resetPulse <= 1'b0;
    end else begin
      armPulse   <= takeOp && (rxData == OP_ARM);
      resetPulse <= takeOp && (rxData == OP_RESET);
    end
  end

  // identification reply sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      replyActive <= 1'b0;
      replyIdx    <= '0;
    end else if (takeOp && (rxData == OP_IDENT)) begin
      replyActive <= 1'b1;
      replyIdx    <= '0;
    end else if (txFire) begin
      if (replyIdx == ID_IDX_W'(ID_LEN - 1)) replyActive <= 1'b0;
      replyIdx <= replyIdx + 1'b1;
    end
  end

endmodule

// File: rtl/la_cmd_dpath.sv
module la_cmd_dpath
  import la_cmd_pkg::*;
#(
  parameter int ARG_BYTES = 4,
  parameter int DIV_W     = 24,
  parameter int CNT_W     = 32,
  parameter int FLAG_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BYTE_W-1:0]   rxData,
  input  ctrl_strobe_t        stb,
  input  logic [ID_IDX_W-1:0] replyIdx,
  output logic [BYTE_W-1:0]   txData,
  output logic [DIV_W-1:0]    divider,
  output logic [CNT_W-1:0]    readCount,
  output logic [CNT_W-1:0]    delayCount,
  output logic [FLAG_W-1:0]   flags
);

  localparam int ARG_W   = ARG_BYTES * BYTE_W;
  localparam int SHIFT_W = ARG_W - BYTE_W;

  logic [BYTE_W-1:0]  opReg;
  logic [SHIFT_W-1:0] argShift;
  logic [ARG_W-1:0]   argFull;

  assign argFull = {rxData, argShift};
  assign txData  = idByte(replyIdx);

  always_ff @(posedge clk) begin
    if (rst)              opReg <= '0;
    else if (stb.latchOp) opReg <= rxData;
  end

  // bytes arrive least significant first: shift in from the top
  generate
    if (ARG_BYTES > 2) begin : g_multi_lane
      always_ff @(posedge clk) begin
        if (rst)               argShift <= '0;
        else if (stb.shiftArg) argShift <= {rxData, argShift[SHIFT_W-1:BYTE_W]};
      end
    end else begin : g_single_lane
      always_ff @(posedge clk) begin
        if (rst)               argShift <= '0;
        else if (stb.shiftArg) argShift <= rxData;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      divider    <= '0;
      readCount  <= '0;
      delayCount <= '0;
      flags      <= '0;
    end else if (stb.commit) begin
      case (opReg)
        OP_DIV:   divider    <= argFull[DIV_W-1:0];
        OP_READ:  readCount  <= argFull[CNT_W-1:0];
        OP_DELAY: delayCount <= argFull[CNT_W-1:0];
        OP_FLAGS: flags      <= argFull[FLAG_W-1:0];
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/la_cmd_decoder.sv
module la_cmd_decoder
  import la_cmd_pkg::*;
#(
  parameter int ARG_BYTES = 4,
  parameter int DIV_W     = 24,
  parameter int CNT_W     = 32,
  parameter int FLAG_W    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  output logic              rxReady,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txReady,
  output logic              armPulse,
  output logic              resetPulse,
  output logic [DIV_W-1:0]  divider,
  output logic [CNT_W-1:0]  readCount,
  output logic [CNT_W-1:0]  delayCount,
  output logic [FLAG_W-1:0] flags
);

  ctrl_strobe_t        stb;
  logic [ID_IDX_W-1:0] replyIdx;

  la_cmd_ctrl #(.ARG_BYTES(ARG_BYTES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .rxValid    (rxValid),
    .rxData     (rxData),
    .rxReady    (rxReady),
    .txValid    (txValid),
    .txReady    (txReady),
    .replyIdx   (replyIdx),
    .stb        (stb),
    .armPulse   (armPulse),
    .resetPulse (resetPulse)
  );

  la_cmd_dpath #(
    .ARG_BYTES (ARG_BYTES),
    .DIV_W     (DIV_W),
    .CNT_W     (CNT_W),
    .FLAG_W    (FLAG_W)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .rxData     (rxData),
    .stb        (stb),
    .replyIdx   (replyIdx),
    .txData     (txData),
    .divider    (divider),
    .readCount  (readCount),
    .delayCount (delayCount),
    .flags      (flags)
  );

endmodule

// File: rtl/la_cmd_checker.sv
module la_cmd_checker #(
  parameter int DIV_W  = 24,
  parameter int CNT_W  = 32,
  parameter int FLAG_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rxValid,
  input logic [7:0]        rxData,
  input logic              rxReady,
  input logic              txValid,
  input logic [7:0]        txData,
  input logic              txReady,
  input logic              armPulse,
  input logic              resetPulse,
  input logic [DIV_W-1:0]  divider,
  input logic [CNT_W-1:0]  readCount,
  input logic [CNT_W-1:0]  delayCount,
  input logic [FLAG_W-1:0] flags
);

  AST_ARM_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
    armPulse |-> $past(rxValid && rxReady && rxData == 8'h01)); // R2

  AST_RESET_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
    resetPulse |-> $past(rxValid && rxReady && rxData == 8'h00)); // R3

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $countones({armPulse, resetPulse}) <= 1); // R3

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txReady) |=> (txValid && $stable(txData))); // R4

  AST_RX_BLOCKED_IN_REPLY: assert property (@(posedge clk) disable iff (rst)
    txValid |-> !rxReady); // R5

  AST_REGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(rxValid && rxReady) |=> ($stable(divider) && $stable(readCount)
                               && $stable(delayCount) && $stable(flags))); // R6

endmodule

bind la_cmd_decoder la_cmd_checker #(
  .DIV_W  (DIV_W),
  .CNT_W  (CNT_W),
  .FLAG_W (FLAG_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rxValid    (rxValid),
  .rxData     (rxData),
  .rxReady    (rxReady),
  .txValid    (txValid),
  .txData     (txData),
  .txReady    (txReady),
  .armPulse   (armPulse),
  .resetPulse (resetPulse),
  .divider    (divider),
  .readCount  (readCount),
  .delayCount (delayCount),
  .flags      (flags)
);

// File: tb/tb_la_cmd_decoder.sv
module tb_la_cmd_decoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = 8'h00;
  logic        rxReady;
  logic        txValid;
  logic [7:0]  txData;
  logic        txReady = 1'b0;
  logic        armPulse;
  logic        resetPulse;
  logic [23:0] divider;
  logic [31:0] readCount;
  logic [31:0] delayCount;
  logic [15:0] flags;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [23:0] mDiv   = '0;
  logic [31:0] mRead  = '0;
  logic [31:0] mDelay = '0;
  logic [15:0] mFlags = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  la_cmd_decoder dut (
    .clk(clk), .rst(rst), .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .armPulse(armPulse), .resetPulse(resetPulse), .divider(divider),
    .readCount(readCount), .delayCount(delayCount), .flags(flags)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expId(input int i);
    case (i)
      0: return 8'h31;
      1: return 8'h53;
      2: return 8'h4C;
      default: return 8'h4F;
    endcase
  endfunction

  function automatic void applyModel(input logic [7:0] op, input logic [31:0] arg);
    case (op)
      8'h80: mDiv   = arg[23:0];
      8'h81: mRead  = arg;
      8'h82: mFlags = arg[15:0];
      8'h83: mDelay = arg;
      default: ;
    endcase
  endfunction

  // byte is accepted at the rising edge before return; sample strobes at return
  task automatic sendByte(input logic [7:0] b, output logic sawArm, output logic sawRst);
    @(negedge clk);
    rxValid = 1'b1;
    rxData  = b;
    while (!rxReady) @(negedge clk);
    @(negedge clk);
    rxValid = 1'b0;
    sawArm  = armPulse;
    sawRst  = resetPulse;
  endtask

  task automatic checkRegs(input string req);
    chk({req, " divider"},    {8'h00, divider}, {8'h00, mDiv});
    chk({req, " readCount"},  readCount,  mRead);
    chk({req, " delayCount"}, delayCount, mDelay);
    chk({req, " flags"},      {16'h0, flags}, {16'h0, mFlags});
  endtask

  task automatic sendLong(input logic [7:0] op, input logic [31:0] arg, input string req);
    logic a, r;
    sendByte(op, a, r);
    chk({req, " no strobe on opcode"}, {30'h0, a, r}, 32'h0);
    for (int j = 0; j < 4; j++) begin
      sendByte(arg[8*j +: 8], a, r);
      chk("R12 no strobe on argument byte", {30'h0, a, r}, 32'h0);
      chk("R12 no reply on argument byte", {31'h0, txValid}, 32'h0);
    end
    applyModel(op, arg);
    checkRegs(req);
  endtask

  // called right after the identify byte was accepted
  task automatic readReply(input bit stall);
    if (stall) begin
      for (int s = 0; s < 3; s++) begin
        chk("R4 txValid during stall", {31'h0, txValid}, 32'h1);
        chk("R4 txData held during stall", {24'h0, txData}, {24'h0, expId(0)});
        chk("R5 rxReady low during reply", {31'h0, rxReady}, 32'h0);
        @(negedge clk);
      end
    end
    txReady = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R4 reply byte valid", {31'h0, txValid}, 32'h1);
      chk("R4 reply byte value", {24'h0, txData}, {24'h0, expId(i)});
      @(negedge clk);
    end
    txReady = 1'b0;
    chk("R4 reply ends", {31'h0, txValid}, 32'h0);
    chk("R5 rxReady back high", {31'h0, rxReady}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic a, r;
    logic [7:0]  op;
    logic [31:0] arg;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checkRegs("R1");
    chk("R1 strobes", {30'h0, armPulse, resetPulse}, 32'h0);
    chk("R1 txValid", {31'h0, txValid}, 32'h0);
    chk("R1 rxReady", {31'h0, rxReady}, 32'h1);

    // R2 arm
    sendByte(8'h01, a, r);
    chk("R2 arm pulse", {30'h0, a, r}, 32'h2);
    @(negedge clk);
    chk("R2 arm one cycle", {31'h0, armPulse}, 32'h0);

    // R7 R8 R9 directed loads, R12 argument bytes equal to opcodes
    sendLong(8'h80, 32'hAB12_3456, "R7");
    sendLong(8'h81, 32'h0201_0201, "R8");
    sendLong(8'h83, 32'hFFFF_FFFE, "R8");
    sendLong(8'h82, 32'h0000_0102, "R9");
    sendLong(8'h82, 32'hDEAD_BEEF, "R9");

    // R3 reset keeps registers
    sendByte(8'h00, a, r);
    chk("R3 reset pulse", {30'h0, a, r}, 32'h1);
    @(negedge clk);
    chk("R3 reset one cycle", {31'h0, resetPulse}, 32'h0);
    checkRegs("R3");

    // R4 R5 identify, with and without stall
    sendByte(8'h02, a, r);
    readReply(1'b1);
    sendByte(8'h02, a, r);
    readReply(1'b0);

    // R10 unknown short then long
    sendByte(8'h05, a, r);
    chk("R10 unknown short no strobe", {30'h0, a, r}, 32'h0);
    sendLong(8'h81, 32'h1357_9BDF, "R10");
    // R10 unknown long with opcode-like args, then arm must be decoded
    sendLong(8'h9C, 32'h8082_0201, "R10");
    sendByte(8'h01, a, r);
    chk("R10 alignment after unknown long", {30'h0, a, r}, 32'h2);

    // R11 resync after k argument bytes
    for (int k = 0; k < 4; k++) begin
      sendByte(8'h81, a, r);
      arg = '0;
      for (int j = 0; j < k; j++) begin
        arg[8*j +: 8] = 8'h11 * (j + 1);
        sendByte(arg[8*j +: 8], a, r);
      end
      for (int z = 0; z < 5; z++) sendByte(8'h00, a, r);
      chk("R11 fifth zero is reset", {30'h0, a, r}, 32'h1);
      applyModel(8'h81, arg);
      checkRegs("R11");
      sendLong(8'h83, 32'h0A0B_0C00 + k, "R11");
    end

    // random mix
    for (int it = 0; it < 80; it++) begin
      int sel;
      sel = $urandom_range(0, 5);
      arg = $urandom;
      if (sel < 4) begin
        sendLong(8'h80 + 8'(sel), arg, "R6");
      end else if (sel == 4) begin
        op = 8'(3 + $urandom_range(0, 124));
        sendByte(op, a, r);
        chk("R10 random unknown short", {30'h0, a, r}, 32'h0);
        checkRegs("R10");
      end else begin
        op = 8'(8'h84 + $urandom_range(0, 123));
        sendLong(op, arg, "R10");
      end
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule